// File: doc/BRIEF.md
# Card Transfer Sequencing Controller

This block is the control and sequencing core of a memory-card host interface. Firmware starts each phase of a card transaction by setting a one-shot bit through a byte-wide register port. The phases are sending a command, capturing the card's response, and moving a data block. The block drives a start or arm level to the matching shifter for as long as the bit is set. It clears the bit itself when that shifter reports completion.

A data phase can run at once, or it can wait for a response. In the write direction, the block also waits a programmable number of card clocks after the response before it lets outgoing data start. Each line controller has a self-clearing soft-reset bit. A master enable freezes the whole sequencer. A card-clock tick, produced by dividing the system clock, either runs freely or pauses while the shifters ask for flow control.

Top module: `card_seq_ctrl`

## Requirements
- R1: After reset both registers read 0x00, and `cmd_start`, `rsp_arm`, `dat_run`, `cmd_ctl_rst`, `dat_ctl_rst` and `card_tick` are low.
- R2: Register PHASE (address 0) bit 0 is the command-go bit. While it is set and the master enable is on, `cmd_start` is high. A `cmd_sent` pulse clears the bit.
- R3: PHASE bit 1 is the response-arm bit. While it is set and the master enable is on, `rsp_arm` is high. A `rsp_done` pulse clears the bit.
- R4: PHASE bit 2 is data-go, bit 3 selects the direction (1 = write to card), and bit 4 selects waiting for a response. With bit 4 at 0, `dat_run` rises the cycle after data-go is seen. A read phase ends only on `rx_crc_done` and a write phase ends only on `tx_busy_done`. The end event clears data-go and `dat_run`, and the other event has no effect.
- R5: In a read phase that waits for a response, `dat_run` is high in the cycle right after the `rsp_done` pulse.
- R6: In a write phase that waits for a response, `dat_run` rises after exactly 3 + 2·G `card_tick` pulses following `rsp_done`. G is register SETUP (address 1) bits 2:1.
- R7: If a completion event and a firmware write of 1 to the same one-shot bit fall in the same cycle, the bit ends up 0.
- R8: SETUP bit 5 is the command-controller reset. After it is written to 1 it reads 1 and drives `cmd_ctl_rst` for exactly one cycle. It then returns to 0 and clears PHASE bits 0 and 1.
- R9: SETUP bit 6 is the data-controller reset. It drives `dat_ctl_rst` for exactly one cycle, then clears data-go, `dat_run` and the CRC error flag.
- R10: With the master enable (SETUP bit 0) on, `card_tick` pulses once every CLK_DIV cycles. When force-clock (SETUP bit 7) is 0 and `flow_hold` is high, the ticks stop. When force-clock is 1, they continue regardless of `flow_hold`.
- R11: With the master enable off, `card_tick`, `cmd_start`, `rsp_arm` and `dat_run` stay low. Completion inputs are ignored, so the one-shot bits keep their values.
- R12: A `dat_crc_bad` pulse sets the CRC error flag, which reads as PHASE bit 7. Only the data-controller reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 PHASE, 1 SETUP |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cmd_sent | input | 1 | Command shifter finished sending |
| rsp_done | input | 1 | Response fully captured |
| rx_crc_done | input | 1 | Read data block and its CRC received |
| tx_busy_done | input | 1 | Card busy ended after a written block |
| dat_crc_bad | input | 1 | Data CRC mismatch seen |
| flow_hold | input | 1 | Shifters request a clock pause |
| cmd_start | output | 1 | Command shifter may send |
| rsp_arm | output | 1 | Response capture armed |
| dat_run | output | 1 | Data shifter may move data |
| cmd_ctl_rst | output | 1 | Command line controller reset |
| dat_ctl_rst | output | 1 | Data line controller reset |
| card_tick | output | 1 | One pulse per card clock period |

## Verification
The bench builds the block with CLK_DIV = 3, so that one card clock lasts three system cycles. With that setting, even the longest turnaround of nine card clocks ends within about thirty cycles. Any twelve-cycle window also holds exactly four ticks, which gives fixed expected counts for the free-running, paused and forced clock cases. Both the shortest and the longest gap settings are measured by counting ticks at the ports.

// File: rtl/card_seq_pkg.sv
// Package: shared register addresses, bit positions and data-phase states
// for the card transfer sequencing controller.
package card_seq_pkg;
    localparam logic ADDR_PHASE = 1'b0;
    localparam logic ADDR_SETUP = 1'b1;

    // PHASE register bits
    localparam int PH_CMD_GO   = 0;
    localparam int PH_RSP_GO   = 1;
    localparam int PH_DAT_GO   = 2;
    localparam int PH_DAT_TX   = 3;
    localparam int PH_WAIT_RSP = 4;
    localparam int PH_CRC_ERR  = 7;

    // SETUP register bits
    localparam int SU_ENABLE   = 0;
    localparam int SU_GAP_LO   = 1;
    localparam int GAP_W       = 2;
    localparam int SU_CMD_RST  = 5;
    localparam int SU_DAT_RST  = 6;
    localparam int SU_FORCE    = 7;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_WAIT_RSP,
        DS_DELAY,
        DS_RUN
    } dat_state_t;
endpackage

// File: rtl/card_seq_regs.sv
// Module: card_seq_regs
// Holds the PHASE and SETUP registers. One-shot bits are set by firmware
// and cleared by completion events; a clear always beats a same-cycle
// write. Soft-reset bits last one cycle. Assumes clear inputs are already
// gated by the master enable.
module card_seq_regs
    import card_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             cmd_clr,
    input  logic             rsp_clr,
    input  logic             dat_clr,
    input  logic             crc_bad,
    output logic             cmd_go,
    output logic             rsp_go,
    output logic             dat_go,
    output logic             dat_tx,
    output logic             wait_rsp,
    output logic             crc_err,
    output logic             master_en,
    output logic [GAP_W-1:0] gap,
    output logic             cmd_rst,
    output logic             dat_rst,
    output logic             force_clk
);
    logic wr_phase;
    logic wr_setup;

    assign wr_phase = we && (addr == ADDR_PHASE);
    assign wr_setup = we && (addr == ADDR_SETUP);

    // Command and response one-shot bits: clear beats write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_go <= 1'b0;
            rsp_go <= 1'b0;
        end else begin
            if (cmd_clr || cmd_rst)
                cmd_go <= 1'b0;
            else if (wr_phase)
                cmd_go <= wdata[PH_CMD_GO];
            if (rsp_clr || cmd_rst)
                rsp_go <= 1'b0;
            else if (wr_phase)
                rsp_go <= wdata[PH_RSP_GO];
        end
    end

    // Data-phase controls: go bit clears on end or data reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_go   <= 1'b0;
            dat_tx   <= 1'b0;
            wait_rsp <= 1'b0;
        end else begin
            if (dat_clr || dat_rst)
                dat_go <= 1'b0;
            else if (wr_phase)
                dat_go <= wdata[PH_DAT_GO];
            if (wr_phase) begin
                dat_tx   <= wdata[PH_DAT_TX];
                wait_rsp <= wdata[PH_WAIT_RSP];
            end
        end
    end

    // CRC error flag: set by the data shifter, cleared by data reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_err <= 1'b0;
        else if (dat_rst)
            crc_err <= 1'b0;
        else if (crc_bad)
            crc_err <= 1'b1;
    end

    // SETUP register, with self-clearing reset bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_en <= 1'b0;
            gap       <= '0;
            force_clk <= 1'b0;
            cmd_rst   <= 1'b0;
            dat_rst   <= 1'b0;
        end else begin
            if (wr_setup) begin
                master_en <= wdata[SU_ENABLE];
                gap       <= wdata[SU_GAP_LO +: GAP_W];
                force_clk <= wdata[SU_FORCE];
            end
            if (cmd_rst)
                cmd_rst <= 1'b0;
            else if (wr_setup)
                cmd_rst <= wdata[SU_CMD_RST];
            if (dat_rst)
                dat_rst <= 1'b0;
            else if (wr_setup)
                dat_rst <= wdata[SU_DAT_RST];
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = 8'h00;
        if (addr == ADDR_PHASE) begin
            rdata[PH_CMD_GO]   = cmd_go;
            rdata[PH_RSP_GO]   = rsp_go;
            rdata[PH_DAT_GO]   = dat_go;
            rdata[PH_DAT_TX]   = dat_tx;
            rdata[PH_WAIT_RSP] = wait_rsp;
            rdata[PH_CRC_ERR]  = crc_err;
        end else begin
            rdata[SU_ENABLE]             = master_en;
            rdata[SU_GAP_LO +: GAP_W]    = gap;
            rdata[SU_CMD_RST]            = cmd_rst;
            rdata[SU_DAT_RST]            = dat_rst;
            rdata[SU_FORCE]              = force_clk;
        end
    end

    AST_CMD_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (!cmd_rst && !cmd_go && !rsp_go)); // R8
    AST_DAT_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rst |=> (!dat_rst && !dat_go && !crc_err)); // R9
    AST_CMD_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr |=> !cmd_go); // R7
    AST_DAT_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dat_clr |=> !dat_go); // R7
endmodule

// File: rtl/card_seq_clkgate.sv
// Module: card_seq_clkgate
// Divides the system clock into one tick per CLK_DIV cycles. It runs while
// enabled and either forced on or not held by flow control; while paused
// the phase counter keeps its value.
module card_seq_clkgate #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic force_on,
    input  logic hold,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

    logic             running;
    logic [DIV_W-1:0] phase;

    assign running = enable && (force_on || !hold);
    assign tick    = running && (phase == LAST);

    // Phase counter advances only while the clock runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (running)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (CLK_DIV > 1 && tick) |=> !tick); // R10
    AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick); // R11
endmodule

// File: rtl/card_seq_datfsm.sv
// Module: card_seq_datfsm
// Sequences the data phase: an optional wait for the response, then in the
// write direction a turnaround of GAP_BASE + GAP_STEP*gap card ticks, then
// run until the direction's end event. Frozen while not enabled; a data
// reset or a cleared go bit returns it to idle.
module card_seq_datfsm
    import card_seq_pkg::*;
#(
    parameter int GAP_BASE = 3,
    parameter int GAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             go,
    input  logic             tx,
    input  logic             wait_rsp,
    input  logic [GAP_W-1:0] gap,
    input  logic             abort,
    input  logic             rsp_evt,
    input  logic             rx_end,
    input  logic             tx_end,
    input  logic             tick,
    output logic             run,
    output logic             done
);
    localparam int GAP_MAX = GAP_BASE + GAP_STEP * ((1 << GAP_W) - 1);
    localparam int CNT_W   = $clog2(GAP_MAX + 1);

    dat_state_t       state;
    logic [CNT_W-1:0] remain;

    assign run  = enable && (state == DS_RUN);
    assign done = run && (tx ? tx_end : rx_end);

    // Data-phase state machine with turnaround counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DS_IDLE;
            remain <= '0;
        end else if (abort || !go) begin
            state  <= DS_IDLE;
        end else if (enable) begin
            case (state)
                DS_IDLE:
                    state <= wait_rsp ? DS_WAIT_RSP : DS_RUN;
                DS_WAIT_RSP:
                    if (rsp_evt) begin
                        if (tx) begin
                            state  <= DS_DELAY;
                            remain <= CNT_W'(GAP_BASE) + CNT_W'(GAP_STEP) * CNT_W'(gap);
                        end else begin
                            state <= DS_RUN;
                        end
                    end
                DS_DELAY:
                    if (tick) begin
                        if (remain <= CNT_W'(1))
                            state <= DS_RUN;
                        else
                            remain <= remain - 1'b1;
                    end
                DS_RUN:
                    if (done)
                        state <= DS_IDLE;
                default:
                    state <= DS_IDLE;
            endcase
        end
    end

    AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_DELAY) |-> (remain != '0 && remain <= CNT_W'(GAP_MAX))); // R6
    AST_RUN_LEAVES_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_RUN && !go) |=> (state == DS_IDLE)); // R4
endmodule

// File: rtl/card_seq_ctrl.sv
// Module: card_seq_ctrl (top)
// Control-register and sequencing core of a card host interface. Ties the
// register file, the data-phase sequencer and the card clock divider
// together, and gates every handshake with the master enable.
// Assumes completion inputs are single-cycle pulses in the system clock.
module card_seq_ctrl
    import card_seq_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int GAP_BASE = 3,
    parameter int GAP_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cmd_sent,
    input  logic       rsp_done,
    input  logic       rx_crc_done,
    input  logic       tx_busy_done,
    input  logic       dat_crc_bad,
    input  logic       flow_hold,
    output logic       cmd_start,
    output logic       rsp_arm,
    output logic       dat_run,
    output logic       cmd_ctl_rst,
    output logic       dat_ctl_rst,
    output logic       card_tick
);
    logic             cmd_go, rsp_go, dat_go, dat_tx, wait_rsp, crc_err;
    logic             master_en, force_clk, cmd_rst, dat_rst;
    logic [GAP_W-1:0] gap;
    logic             cmd_clr, rsp_clr, dat_clr, crc_bad_en;

    // Completion events count only while the controller is enabled
    assign cmd_clr    = master_en && cmd_sent;
    assign rsp_clr    = master_en && rsp_done;
    assign crc_bad_en = master_en && dat_crc_bad;

    assign cmd_start   = master_en && cmd_go;
    assign rsp_arm     = master_en && rsp_go;
    assign cmd_ctl_rst = cmd_rst;
    assign dat_ctl_rst = dat_rst;

    card_seq_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cmd_clr   (cmd_clr),
        .rsp_clr   (rsp_clr),
        .dat_clr   (dat_clr),
        .crc_bad   (crc_bad_en),
        .cmd_go    (cmd_go),
        .rsp_go    (rsp_go),
        .dat_go    (dat_go),
        .dat_tx    (dat_tx),
        .wait_rsp  (wait_rsp),
        .crc_err   (crc_err),
        .master_en (master_en),
        .gap       (gap),
        .cmd_rst   (cmd_rst),
        .dat_rst   (dat_rst),
        .force_clk (force_clk)
    );

    card_seq_datfsm #(
        .GAP_BASE (GAP_BASE),
        .GAP_STEP (GAP_STEP)
    ) i_datfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (master_en),
        .go       (dat_go),
        .tx       (dat_tx),
        .wait_rsp (wait_rsp),
        .gap      (gap),
        .abort    (dat_rst),
        .rsp_evt  (rsp_clr),
        .rx_end   (rx_crc_done),
        .tx_end   (tx_busy_done),
        .tick     (card_tick),
        .run      (dat_run),
        .done     (dat_clr)
    );

    card_seq_clkgate #(
        .CLK_DIV (CLK_DIV)
    ) i_clkgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (master_en),
        .force_on (force_clk),
        .hold     (flow_hold),
        .tick     (card_tick)
    );

    AST_FROZEN_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !reg_we && !cmd_rst) |=> $stable(cmd_go)); // R11
    AST_FROZEN_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (!dat_run && !cmd_start && !rsp_arm)); // R11
    AST_CRC_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !dat_rst) |=> crc_err); // R12
endmodule

// File: tb/test_card_seq_ctrl.sv
// Directed bench for card_seq_ctrl: one task per scenario; inputs driven and
// outputs sampled at the falling edge.
module test_card_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       cmd_sent, rsp_done, rx_crc_done, tx_busy_done, dat_crc_bad, flow_hold;
    logic       cmd_start, rsp_arm, dat_run, cmd_ctl_rst, dat_ctl_rst, card_tick;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    card_seq_ctrl #(.CLK_DIV(DIV)) i_card_seq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cmd_sent     (cmd_sent),
        .rsp_done     (rsp_done),
        .rx_crc_done  (rx_crc_done),
        .tx_busy_done (tx_busy_done),
        .dat_crc_bad  (dat_crc_bad),
        .flow_hold    (flow_hold),
        .cmd_start    (cmd_start),
        .rsp_arm      (rsp_arm),
        .dat_run      (dat_run),
        .cmd_ctl_rst  (cmd_ctl_rst),
        .dat_ctl_rst  (dat_ctl_rst),
        .card_tick    (card_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // which: 0 cmd_sent, 1 rsp_done, 2 rx_crc_done, 3 tx_busy_done, 4 dat_crc_bad
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cmd_sent = 1'b1;
            1: rsp_done = 1'b1;
            2: rx_crc_done = 1'b1;
            3: tx_busy_done = 1'b1;
            default: dat_crc_bad = 1'b1;
        endcase
        @(negedge clk);
        cmd_sent = 0; rsp_done = 0; rx_crc_done = 0; tx_busy_done = 0; dat_crc_bad = 0;
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            if (card_tick) n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 phase reg", v, 0);
        rd(1'b1, v); chk("R1 setup reg", v, 0);
        chk("R1 outputs", {cmd_start, rsp_arm, dat_run, cmd_ctl_rst, dat_ctl_rst, card_tick}, 0);
    endtask

    task automatic t_cmd_rsp();
        logic [7:0] v;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h01);
        chk("R2 cmd_start set", cmd_start, 1);
        pulse(0);
        rd(1'b0, v); chk("R2 cmd bit cleared", v, 0);
        chk("R2 cmd_start low", cmd_start, 0);
        wr(1'b0, 8'h02);
        chk("R3 rsp_arm set", rsp_arm, 1);
        pulse(1);
        rd(1'b0, v); chk("R3 rsp bit cleared", v, 0);
        chk("R3 rsp_arm low", rsp_arm, 0);
    endtask

    task automatic t_immediate();
        logic [7:0] v;
        wr(1'b0, 8'h04);
        @(negedge clk);
        chk("R4 rx run", dat_run, 1);
        pulse(3);
        rd(1'b0, v); chk("R4 rx ignores busy end", {dat_run, v}, {1'b1, 8'h04});
        pulse(2);
        rd(1'b0, v); chk("R4 rx ends on crc", {dat_run, v}, 0);
        wr(1'b0, 8'h0C);
        @(negedge clk);
        chk("R4 tx run", dat_run, 1);
        pulse(2);
        rd(1'b0, v); chk("R4 tx ignores crc", {dat_run, v}, {1'b1, 8'h0C});
        pulse(3);
        rd(1'b0, v); chk("R4 tx ends on busy", {dat_run, v}, {1'b0, 8'h08});
    endtask

    task automatic t_rx_after_rsp();
        wr(1'b0, 8'h14);
        @(negedge clk);
        chk("R5 waits for response", dat_run, 0);
        pulse(1);
        chk("R5 run right after response", dat_run, 1);
        pulse(2);
        chk("R5 ended", dat_run, 0);
    endtask

    task automatic t_tx_gap(input int g);
        int n = 0;
        int guard = 0;
        wr(1'b1, 8'(8'h01 | (g << 1)));
        wr(1'b0, 8'h1C);
        @(negedge clk);
        pulse(1);
        while (!dat_run && guard < 200) begin
            if (card_tick) n++;
            guard++;
            @(negedge clk);
        end
        chk("R6 turnaround ticks", n, 3 + 2 * g);
        pulse(3);
        chk("R6 write ended", dat_run, 0);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h01);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h01; cmd_sent = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; cmd_sent = 1'b0;
        rd(1'b0, v); chk("R7 clear beats write", v, 0);
    endtask

    task automatic t_cmd_reset();
        logic [7:0] v;
        wr(1'b0, 8'h03);
        wr(1'b1, 8'h21);
        chk("R8 reset pulse high", cmd_ctl_rst, 1);
        @(negedge clk);
        chk("R8 reset pulse over", cmd_ctl_rst, 0);
        rd(1'b0, v); chk("R8 phase bits cleared", v, 0);
        rd(1'b1, v); chk("R8 setup after reset", v, 8'h01);
    endtask

    task automatic t_dat_reset();
        logic [7:0] v;
        wr(1'b0, 8'h04);
        @(negedge clk);
        pulse(4);
        rd(1'b0, v); chk("R12 crc flag set", v, 8'h84);
        pulse(2);
        rd(1'b0, v); chk("R12 crc flag sticky", v, 8'h80);
        wr(1'b0, 8'h04);
        @(negedge clk);
        wr(1'b1, 8'h41);
        chk("R9 reset pulse high", dat_ctl_rst, 1);
        @(negedge clk);
        chk("R9 reset pulse over", dat_ctl_rst, 0);
        rd(1'b0, v); chk("R9 go and flag cleared", {dat_run, v}, 0);
    endtask

    task automatic t_clock();
        int n;
        wr(1'b1, 8'h01);
        flow_hold = 1'b0;
        count_ticks(12, n); chk("R10 free ticks", n, 12 / DIV);
        flow_hold = 1'b1;
        count_ticks(12, n); chk("R10 held ticks", n, 0);
        wr(1'b1, 8'h81);
        count_ticks(12, n); chk("R10 forced ticks", n, 12 / DIV);
        flow_hold = 1'b0;
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        int n;
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h03);
        chk("R11 frozen outputs", {cmd_start, rsp_arm, dat_run}, 0);
        count_ticks(9, n); chk("R11 no ticks", n, 0);
        pulse(0);
        pulse(1);
        rd(1'b0, v); chk("R11 bits retained", v, 8'h03);
        wr(1'b1, 8'h01);
        chk("R11 resumes", {cmd_start, rsp_arm}, 2'b11);
        pulse(0);
        pulse(1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        cmd_sent = 0; rsp_done = 0; rx_crc_done = 0; tx_busy_done = 0;
        dat_crc_bad = 0; flow_hold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_rsp();
        t_immediate();
        t_rx_after_rsp();
        t_tx_gap(0);
        t_tx_gap(3);
        t_priority();
        t_cmd_reset();
        t_dat_reset();
        t_clock();
        t_freeze();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule